// File: doc/BRIEF.md
# Spill Rate Plot Recorder

This block builds a time profile of pulse rates while a spill is in progress. A four-bit source code picks one of sixteen pulse streams: fourteen input channels, the trigger-candidate stream and the accepted-trigger stream. For as long as the spill level is high, the block counts the chosen stream's pulses over a programmable number of clock cycles. At the end of each interval it stores the count in the next word of a plot memory, so the memory holds one count per interval.

Beside the plot, a second memory collects a histogram of the gaps between accepted triggers. The gap, measured in clocks, is divided by a programmable bin width. Each accepted trigger after the first in a spill adds one to the bin for its gap. Gaps past the end of the histogram land in its last bin.

Both memories, the configuration registers and the current plot write position are reached over a word-addressed register bus. The bus always accepts a request. A read answers exactly one cycle later with a response strobe, and the response cannot be stalled, so the bus has no back-pressure. The spill level and the pulse streams are plain single-cycle-sampled inputs.

Top module: `spill_rate_recorder`

## Requirements
- R1: After reset, the interval-length register reads 1 (low half at 0x08000, high half at 0x08001 reads 0), the bin-width register reads 1 (low half at 0x08002), the source register at 0x08004 reads 0, and the write position at 0x08006 reads 0.
- R2: The source field is bits 3:0 of 0x08004. Codes 0 to 13 select input channels 0 to 13, code 14 selects trigger candidates and code 15 selects accepted triggers. Streams that are not selected do not affect the plot.
- R3: The interval length S is 32 bits, with the low half at 0x08000 and the high half at 0x08001; a value of 0 acts as 1. Spill cycles k = jS to jS+S-1 form interval j. Its pulse count is written to plot bin j in the spill cycle k = (j+1)S, and plot bin j is read at bus address j.
- R4: A pulse in the same spill cycle as an interval boundary (k a multiple of S, k > 0) is counted in the interval that starts there.
- R5: When spill rises, the write position and the interval count restart from zero. An interval still open when spill falls is discarded. Plot bins at or beyond the write position read as 0.
- R6: The plot holds 2^PLOT_AW bins (2048 by default). Once the last bin has been written, the write position stays at 2^PLOT_AW and further interval counts are dropped without wrapping. Bus addresses from 2^PLOT_AW up to 0x01FFF read 0.
- R7: The write position reads as a 32-bit value, with the low half at 0x08006 and the high half at 0x08007.
- R8: The bin width H is 32 bits (low at 0x08002, high at 0x08003; 0 acts as 1). Each accepted trigger during a spill, other than the first trigger of that spill, adds 1 to histogram bin min(floor(gap/H), 1023), where gap is the clock distance to the previous accepted trigger. Histogram bin b is read at 0x10000 + b. All bins read 0 after a spill starts.
- R9: A read request returns data with the response strobe high in the next cycle, and a write gives no response. Writes to the memories, to the write-position registers and to unmapped addresses have no effect. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| spill_i | input | 1 | Spill-in-progress level |
| chan_pulse_i | input | NCHAN (14) | Per-channel pulse flags, one cycle each |
| trig_cand_i | input | 1 | Trigger-candidate pulse |
| trig_acc_i | input | 1 | Accepted-trigger pulse |
| bus_req_i | input | 1 | Bus request, accepted every cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 17 | Word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rsp_valid_o | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata_o | output | 16 | Read data |

## Verification
On every cycle, the embedded properties check three things about the plot write position: it stays within the plot depth, it only ever advances by one or returns to zero, and it holds once the plot is full. They also check that a spill start clears the write position, that the histogram bin timer saturates without wrapping and restarts after each trigger, and that the response strobe follows reads and never writes. The count values themselves can only be shown by the bench's scenarios. These include which source reaches the plot, where pulses that coincide with a boundary are attributed, treating a zero interval as one, discarding an open interval, the gap-to-bin mapping with saturation into the last bin, and the histogram clearing at a spill start.

// File: rtl/srr_pkg.sv
package srr_pkg;
  localparam int ADDR_W = 17;
  localparam int DATA_W = 16;
  localparam logic [ADDR_W-1:0] A_STEP_LO  = 17'h08000;
  localparam logic [ADDR_W-1:0] A_STEP_HI  = 17'h08001;
  localparam logic [ADDR_W-1:0] A_HSTEP_LO = 17'h08002;
  localparam logic [ADDR_W-1:0] A_HSTEP_HI = 17'h08003;
  localparam logic [ADDR_W-1:0] A_SRC      = 17'h08004;
  localparam logic [ADDR_W-1:0] A_WPTR_LO  = 17'h08006;
  localparam logic [ADDR_W-1:0] A_WPTR_HI  = 17'h08007;
  localparam logic [ADDR_W-1:0] A_HIST_BASE = 17'h10000;

  typedef enum logic [1:0] {RK_NONE, RK_PLOT, RK_HIST, RK_REG} rd_kind_e;

  // A zero length is treated as a one-cycle length.
  function automatic logic [31:0] eff_len(input logic [31:0] v);
    return (v == 32'd0) ? 32'd1 : v;
  endfunction
endpackage

// File: rtl/rate_bin_writer.sv
module rate_bin_writer #(
  parameter int AW    = 11,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spill_i,
  input  logic             pulse_i,
  input  logic [31:0]      step_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_idx_i,
  output logic [AW:0]      wptr_o,
  output logic [CNT_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] mem [DEPTH];
  logic             spill_q;
  logic [31:0]      tick_q;
  logic [CNT_W-1:0] cnt_q;
  logic [AW:0]      wptr_q;
  logic             rise, boundary, wr_ok;
  logic [31:0]      len;
  logic [CNT_W-1:0] cnt_inc;

  assign rise     = spill_i && !spill_q;
  assign len      = srr_pkg::eff_len(step_i);
  assign boundary = spill_i && !rise && (tick_q >= len);
  assign wr_ok    = boundary && (wptr_q != FULL);
  assign cnt_inc  = (cnt_q == CMAX) ? CMAX : cnt_q + CNT_W'(pulse_i);

  // tick_q = cycles already spent in the open interval
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spill_q <= 1'b0;
      tick_q  <= '0;
      cnt_q   <= '0;
      wptr_q  <= '0;
    end else begin
      spill_q <= spill_i;
      if (rise) begin
        tick_q <= 32'd1;
        cnt_q  <= CNT_W'(pulse_i);
        wptr_q <= '0;
      end else if (spill_i) begin
        if (boundary) begin
          tick_q <= 32'd1;
          cnt_q  <= CNT_W'(pulse_i);   // boundary pulse opens new interval
          if (wr_ok) wptr_q <= wptr_q + 1'b1;
        end else begin
          tick_q <= tick_q + 32'd1;
          cnt_q  <= cnt_inc;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q[AW-1:0]] <= cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data_o <= '0;
    else if (rd_en_i)
      rd_data_o <= ({1'b0, rd_idx_i} < wptr_q) ? mem[rd_idx_i] : '0;
  end

  assign wptr_o = wptr_q;

  assert_ptr_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_q <= FULL);
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr_q != $past(wptr_q)) |-> (wptr_q == (AW+1)'($past(wptr_q) + 1'b1) || wptr_q == '0));
  assert_full_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr_q == FULL && !rise) |=> (wptr_q == FULL));
  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (spill_i && !spill_q) |=> (wptr_q == '0));
endmodule

// File: rtl/gap_histogram.sv
module gap_histogram #(
  parameter int AW    = 10,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spill_i,
  input  logic             trig_i,
  input  logic [31:0]      hstep_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_idx_i,
  output logic [CNT_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] hmem [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic             spill_q, armed_q;
  logic [AW-1:0]    bin_q;
  logic [31:0]      sub_q;
  logic             rise, restart, do_inc, wrap_sub;
  logic [31:0]      width;

  assign rise     = spill_i && !spill_q;
  assign restart  = spill_i && trig_i;
  assign do_inc   = restart && armed_q && !rise;
  assign width    = srr_pkg::eff_len(hstep_i);
  assign wrap_sub = ({1'b0, sub_q} + 33'd1) >= {1'b0, width};

  // bin_q/sub_q hold floor/remainder of the gap for the current cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spill_q <= 1'b0;
      armed_q <= 1'b0;
      bin_q   <= '0;
      sub_q   <= '0;
      vld_q   <= '0;
    end else begin
      spill_q <= spill_i;
      if (rise) armed_q <= trig_i;
      else if (restart) armed_q <= 1'b1;
      if (rise) vld_q <= '0;
      else if (do_inc) vld_q[bin_q] <= 1'b1;
      if (restart) begin
        if (width == 32'd1) begin
          bin_q <= AW'(1);
          sub_q <= '0;
        end else begin
          bin_q <= '0;
          sub_q <= 32'd1;
        end
      end else if (wrap_sub) begin
        sub_q <= '0;
        if (bin_q != LAST) bin_q <= bin_q + 1'b1;
      end else begin
        sub_q <= sub_q + 32'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_inc)
      hmem[bin_q] <= !vld_q[bin_q] ? CNT_W'(1) :
                     (hmem[bin_q] == CMAX) ? CMAX : hmem[bin_q] + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= vld_q[rd_idx_i] ? hmem[rd_idx_i] : '0;
  end

  assert_bin_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_q == LAST && !restart) |=> (bin_q == LAST));
  assert_bin_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (bin_q <= AW'(1)));
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (spill_i && !spill_q) |=> (vld_q == '0));
endmodule

// File: rtl/spill_rate_recorder.sv
module spill_rate_recorder
  import srr_pkg::*;
#(
  parameter int NCHAN   = 14,
  parameter int PLOT_AW = 11,
  parameter int HIST_AW = 10,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spill_i,
  input  logic [NCHAN-1:0]  chan_pulse_i,
  input  logic              trig_cand_i,
  input  logic              trig_acc_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic              bus_rsp_valid_o,
  output logic [DATA_W-1:0] bus_rdata_o
);
  localparam int NSRC  = NCHAN + 2;
  localparam int SRC_W = $clog2(NSRC);
  localparam int PLOT_DEPTH = 1 << PLOT_AW;
  localparam int HIST_DEPTH = 1 << HIST_AW;
  localparam logic [ADDR_W-1:0] PLOT_END = ADDR_W'(PLOT_DEPTH);
  localparam logic [ADDR_W-1:0] HIST_END = A_HIST_BASE + ADDR_W'(HIST_DEPTH);

  logic [31:0]      step_q, hstep_q;
  logic [SRC_W-1:0] src_q;
  logic [NSRC-1:0]  src_vec;
  logic             sel_pulse;
  logic             wr, rd, plot_hit, hist_hit;
  logic [PLOT_AW:0] wptr;
  logic [31:0]      wptr32;
  logic [CNT_W-1:0] plot_rd, hist_rd;
  logic [DATA_W-1:0] reg_rd, reg_rd_q;
  rd_kind_e         kind_q;
  logic             rsp_q;

  assign src_vec   = {trig_acc_i, trig_cand_i, chan_pulse_i};
  assign sel_pulse = (int'(src_q) < NSRC) ? src_vec[src_q] : 1'b0;

  assign wr       = bus_req_i && bus_we_i;
  assign rd       = bus_req_i && !bus_we_i;
  assign plot_hit = bus_addr_i < PLOT_END;
  assign hist_hit = (bus_addr_i >= A_HIST_BASE) && (bus_addr_i < HIST_END);
  assign wptr32   = 32'(wptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= 32'd1;
      hstep_q <= 32'd1;
      src_q   <= '0;
    end else if (wr) begin
      case (bus_addr_i)
        A_STEP_LO:  step_q[15:0]   <= bus_wdata_i;
        A_STEP_HI:  step_q[31:16]  <= bus_wdata_i;
        A_HSTEP_LO: hstep_q[15:0]  <= bus_wdata_i;
        A_HSTEP_HI: hstep_q[31:16] <= bus_wdata_i;
        A_SRC:      src_q          <= bus_wdata_i[SRC_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr_i)
      A_STEP_LO:  reg_rd = step_q[15:0];
      A_STEP_HI:  reg_rd = step_q[31:16];
      A_HSTEP_LO: reg_rd = hstep_q[15:0];
      A_HSTEP_HI: reg_rd = hstep_q[31:16];
      A_SRC:      reg_rd = DATA_W'(src_q);
      A_WPTR_LO:  reg_rd = wptr32[15:0];
      A_WPTR_HI:  reg_rd = wptr32[31:16];
      default:    reg_rd = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q    <= 1'b0;
      kind_q   <= RK_NONE;
      reg_rd_q <= '0;
    end else begin
      rsp_q    <= rd;
      reg_rd_q <= reg_rd;
      if (!rd)           kind_q <= RK_NONE;
      else if (plot_hit) kind_q <= RK_PLOT;
      else if (hist_hit) kind_q <= RK_HIST;
      else               kind_q <= RK_REG;
    end
  end

  rate_bin_writer #(.AW(PLOT_AW), .CNT_W(CNT_W)) u_plot (
    .clk(clk), .rst_n(rst_n), .spill_i(spill_i), .pulse_i(sel_pulse),
    .step_i(step_q), .rd_en_i(rd && plot_hit),
    .rd_idx_i(bus_addr_i[PLOT_AW-1:0]), .wptr_o(wptr), .rd_data_o(plot_rd)
  );

  gap_histogram #(.AW(HIST_AW), .CNT_W(CNT_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .spill_i(spill_i), .trig_i(trig_acc_i),
    .hstep_i(hstep_q), .rd_en_i(rd && hist_hit),
    .rd_idx_i(bus_addr_i[HIST_AW-1:0]), .rd_data_o(hist_rd)
  );

  always_comb begin
    case (kind_q)
      RK_PLOT: bus_rdata_o = DATA_W'(plot_rd);
      RK_HIST: bus_rdata_o = DATA_W'(hist_rd);
      RK_REG:  bus_rdata_o = reg_rd_q;
      default: bus_rdata_o = '0;
    endcase
  end
  assign bus_rsp_valid_o = rsp_q;

  assert_rsp_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_i && !bus_we_i) |=> bus_rsp_valid_o);
  assert_rsp_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_i && bus_we_i) |=> !bus_rsp_valid_o);
endmodule

// File: tb/spill_rate_recorder_tb.sv
module spill_rate_recorder_tb;
  import srr_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spill = 1'b0;
  logic [13:0] chan = '0;
  logic cand = 1'b0, acc = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [16:0] addr = '0;
  logic [15:0] wdata = '0;
  logic rsp_valid;
  logic [15:0] rdata;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  spill_rate_recorder u_dut (
    .clk(clk), .rst_n(rst_n), .spill_i(spill), .chan_pulse_i(chan),
    .trig_cand_i(cand), .trig_acc_i(acc), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rsp_valid_o(rsp_valid),
    .bus_rdata_o(rdata)
  );

  // src, step, pulse period of selected stream, expected count per bin
  localparam logic [31:0] VEC [5] = '{
    {8'd0,  8'd8,  8'd2, 8'd4},
    {8'd5,  8'd12, 8'd3, 8'd4},
    {8'd13, 8'd10, 8'd5, 8'd2},
    {8'd14, 8'd6,  8'd3, 8'd2},
    {8'd15, 8'd16, 8'd4, 8'd4}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic streams(input logic [15:0] sv);
    {acc, cand, chan} = sv;
  endtask

  task automatic bus_wr(input logic [16:0] a, input logic [15:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input logic [16:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0;
    chk({tag, " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
    chk(tag, {16'd0, rdata}, {16'd0, exp});
  endtask

  task automatic spill_off();
    @(negedge clk); spill = 1'b0; streams(16'h0000); acc = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(A_STEP_LO, 16'd1, "R1 step lo");
    rd_chk(A_STEP_HI, 16'd0, "R1 step hi");
    rd_chk(A_HSTEP_LO, 16'd1, "R1 hstep lo");
    rd_chk(A_SRC, 16'd0, "R1 src");
    rd_chk(A_WPTR_LO, 16'd0, "R1 wptr");

    // R2/R3 table: other streams held high, selected one pulses every per cycles
    for (int i = 0; i < 5; i++) begin
      int src, st, per, ex;
      src = int'(VEC[i][31:24]); st = int'(VEC[i][23:16]);
      per = int'(VEC[i][15:8]);  ex = int'(VEC[i][7:0]);
      bus_wr(A_STEP_LO, 16'(st));
      bus_wr(A_STEP_HI, 16'd0);
      bus_wr(A_SRC, 16'(src));
      for (int k = 0; k <= 4 * st; k++) begin
        logic [15:0] sv;
        @(negedge clk);
        spill = 1'b1;
        sv = 16'hFFFF;
        sv[src] = (k % per == 0);
        streams(sv);
      end
      spill_off();
      for (int b = 0; b < 4; b++)
        rd_chk(17'(b), 16'(ex), $sformatf("R2 R3 vec%0d bin%0d", i, b));
      rd_chk(A_WPTR_LO, 16'd4, $sformatf("R7 vec%0d wptr", i));
    end

    // R3 step 0 acts as 1: pulses at spill cycles 0 and 2
    bus_wr(A_STEP_LO, 16'd0);
    bus_wr(A_SRC, 16'd3);
    for (int k = 0; k <= 4; k++) begin
      @(negedge clk); spill = 1'b1;
      streams((k == 0 || k == 2) ? 16'h0008 : 16'h0000);
    end
    spill_off();
    rd_chk(17'd0, 16'd1, "R3 step0 bin0");
    rd_chk(17'd1, 16'd0, "R3 step0 bin1");
    rd_chk(17'd2, 16'd1, "R3 step0 bin2");
    rd_chk(17'd3, 16'd0, "R3 step0 bin3");

    // R4 boundary pulses: step 4, pulses at 3,4,8,9
    bus_wr(A_STEP_LO, 16'd4);
    bus_wr(A_SRC, 16'd0);
    for (int k = 0; k <= 12; k++) begin
      @(negedge clk); spill = 1'b1;
      streams((k == 3 || k == 4 || k == 8 || k == 9) ? 16'h0001 : 16'h0000);
    end
    spill_off();
    rd_chk(17'd0, 16'd1, "R4 bin0");
    rd_chk(17'd1, 16'd1, "R4 bin1");
    rd_chk(17'd2, 16'd2, "R4 bin2");
    rd_chk(A_WPTR_LO, 16'd3, "R4 wptr");

    // R5 restart and partial interval discarded
    for (int k = 0; k <= 11; k++) begin
      @(negedge clk); spill = 1'b1; streams(16'h0001);
    end
    spill_off();
    rd_chk(A_WPTR_LO, 16'd2, "R5 wptr");
    rd_chk(17'd1, 16'd4, "R5 bin1");
    rd_chk(17'd2, 16'd0, "R5 stale bin reads 0");

    // R6 fill to the end, no wrap
    bus_wr(A_STEP_LO, 16'd1);
    for (int k = 0; k <= 2068; k++) begin
      @(negedge clk); spill = 1'b1; streams(16'h0001);
    end
    spill_off();
    rd_chk(A_WPTR_LO, 16'h0800, "R6 R7 wptr lo full");
    rd_chk(A_WPTR_HI, 16'h0000, "R7 wptr hi");
    rd_chk(17'h007FF, 16'd1, "R6 last bin");
    rd_chk(17'd0, 16'd1, "R6 bin0 not overwritten");
    rd_chk(17'h00800, 16'd0, "R6 beyond depth");

    // R9 ignored writes and unmapped
    bus_wr(A_WPTR_LO, 16'h1234);
    chk("R9 no rsp on write", {31'd0, rsp_valid}, 32'd0);
    rd_chk(A_WPTR_LO, 16'h0800, "R9 wptr write ignored");
    bus_wr(17'd5, 16'hBEEF);
    rd_chk(17'd5, 16'd1, "R9 plot write ignored");
    bus_wr(17'h09000, 16'h5555);
    rd_chk(17'h09000, 16'd0, "R9 unmapped");
    bus_wr(A_STEP_HI, 16'h0001);
    rd_chk(A_STEP_HI, 16'h0001, "R3 step hi");
    bus_wr(A_STEP_HI, 16'h0000);

    // R8 histogram: H=4, triggers at 0,10,13,14,5014
    bus_wr(A_HSTEP_LO, 16'd4);
    bus_wr(A_HSTEP_HI, 16'd2);
    rd_chk(A_HSTEP_HI, 16'd2, "R8 hstep hi");
    bus_wr(A_HSTEP_HI, 16'd0);
    for (int k = 0; k <= 5014; k++) begin
      @(negedge clk); spill = 1'b1; chan = '0; cand = 1'b0;
      acc = (k == 0 || k == 10 || k == 13 || k == 14 || k == 5014);
    end
    spill_off();
    rd_chk(17'h10000, 16'd2, "R8 bin0");
    rd_chk(17'h10001, 16'd0, "R8 bin1");
    rd_chk(17'h10002, 16'd1, "R8 bin2");
    rd_chk(17'h103FF, 16'd1, "R8 saturated bin");
    @(negedge clk); spill = 1'b1;
    spill_off();
    rd_chk(17'h10000, 16'd0, "R8 cleared at spill start");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule